// File: doc/BRIEF.md
# Fractional M/N Clock Divider

This block derives a slower clock enable and a clock level from a single source clock. It applies two scaling stages in series. The first is a pre-divider that scales in half-integer steps. The second is an optional fractional M/N accumulator with a programmable high-time threshold. The resulting average output rate is the source rate × 2/(hid+1) × m/n. A pre-divider value of zero passes the source rate through unchanged.

The configuration is presented on the input pins in the stored encoding. The denominator and the duty threshold arrive as bitwise complements, and a two-bit mode chooses M/N operation or bypass. A one-cycle request captures the pins into a pending copy. That copy becomes active only at the end of an output period, so a reconfiguration never cuts a period short. A one-cycle commit strobe marks the edge at which the new settings took over. All logic is single-edge and runs in the source clock domain. The half-integer ratio is therefore exact on average rather than symmetric in every period.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is low, clk_en_o, clk_o and commit_done_o are 0. Out of reset, the active configuration is pre-divider 0, mode 0, m = 1, an inverted-n field of all ones and an inverted-duty field of all ones, which gives one clk_en_o pulse per source cycle.
- R2: With pre-divider value hid = 0, the pre-divided tick occurs on every source cycle. With hid ≥ 1, ticks occur on average 2 times per hid+1 source cycles: a half-step accumulator adds 2 each cycle and subtracts hid+1 when it reaches hid+1.
- R3: Mode value 2 (binary 10) enables the M/N stage. Mode values 0, 1 and 3 bypass it, and clk_en_o then follows the pre-divided tick.
- R4: The denominator is decoded as n = (bitwise complement of cfg_n_inv_i, MND_W bits) + m, so a field holding the complement of n−m yields n.
- R5: In M/N mode, each tick adds m to an accumulator. The accumulator wraps modulo n, and clk_en_o pulses on each wrap, so pulses per tick equal m/n.
- R6: In M/N mode, clk_o is 1 while the updated accumulator is below the duty threshold, which is the complement of cfg_d_inv_i over MND_W bits. In bypass, clk_o equals clk_en_o.
- R7: A configuration captured by cfg_req_i becomes active only on an edge where clk_en_o is asserted. commit_done_o pulses in that same cycle, and both accumulators restart from zero.
- R8: A second request made before the pending configuration has been committed replaces it, and only the latest captured configuration is applied.
- R9: Over a long window, the count of clk_en_o pulses per source cycle matches 2/(hid+1) × m/n within two pulses, with the 2/(hid+1) factor taken as 1 for hid = 0.
- R10: clk_en_o and clk_o are registered, and each reflects the accumulator update made on the same source edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_req_i | input | 1 | One-cycle request to capture the configuration pins |
| cfg_hid_i | input | HID_W | Half-step pre-divider value, 0 = bypass |
| cfg_mode_i | input | 2 | Mode, 2 = M/N operation, other values bypass |
| cfg_m_i | input | MND_W | Numerator m |
| cfg_n_inv_i | input | MND_W | Complement of (n − m) |
| cfg_d_inv_i | input | MND_W | Complement of the duty threshold |
| clk_en_o | output | 1 | One-cycle pulse at each output period boundary |
| clk_o | output | 1 | Divided clock level |
| commit_done_o | output | 1 | Pulses when a pending configuration takes effect |

## Verification
The assertions take for granted that m is never zero and that the decoded n fits in MND_W+1 bits, so the accumulator always has a nonzero modulus. They also assume that configuration pins are held steady in the cycle the request is sampled. The stimulus drives only ratios with m ≥ 1 and n−m below 2^MND_W, and it changes pins and the request only on the falling edge. Each configuration is checked against the cycle model and then held for a full counting window.

// File: rtl/frac_div_pkg.sv
`timescale 1ns/1ps
package frac_div_pkg;
  typedef enum logic [1:0] {
    FD_BYPASS = 2'd0,
    FD_RSVD1  = 2'd1,
    FD_DUAL   = 2'd2,
    FD_RSVD3  = 2'd3
  } fd_mode_e;
endpackage

// File: rtl/fd_prediv.sv
`timescale 1ns/1ps
// Half-step pre-divider: average tick rate 2/(hid+1), hid = 0 passes through.
module fd_prediv #(
  parameter int HID_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [HID_W-1:0] hid_i,
  output logic             tick_o
);
  localparam int AW = HID_W + 1;

  logic [AW-1:0] acc_q, acc_d, lim, sum;
  logic          bypass;

  always_comb begin
    lim    = {1'b0, hid_i} + AW'(1);
    sum    = acc_q + AW'(2);
    bypass = (hid_i == '0);
    tick_o = bypass || (sum >= lim);
    if (clr_i || bypass)  acc_d = '0;
    else if (tick_o)      acc_d = sum - lim;
    else                  acc_d = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  // R2
  acc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q <= {1'b0, hid_i});
  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hid_i >= HID_W'(3) && tick_o && !clr_i) |=> !tick_o);
endmodule

// File: rtl/fd_mnd.sv
`timescale 1ns/1ps
// M/N accumulator: adds m per step, wraps modulo n, level from duty threshold.
module fd_mnd #(
  parameter int MND_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [MND_W-1:0] m_i,
  input  logic [MND_W-1:0] n_inv_i,
  input  logic [MND_W-1:0] d_inv_i,
  output logic             wrap_o,
  output logic             lvl_o
);
  localparam int SW = MND_W + 2;

  logic [MND_W-1:0] n_dec, d_dec;
  logic [SW-1:0]    m_w, n_w, duty, sum, acc_q, acc_d;
  logic             over;

  always_comb begin
    n_dec  = ~n_inv_i;
    d_dec  = ~d_inv_i;
    m_w    = SW'(m_i);
    n_w    = SW'(n_dec) + m_w;
    duty   = SW'(d_dec);
    sum    = acc_q + m_w;
    over   = (sum >= n_w);
    wrap_o = step_i && over;
    if (clr_i)        acc_d = '0;
    else if (!step_i) acc_d = acc_q;
    else if (over)    acc_d = sum - n_w;
    else              acc_d = sum;
    lvl_o  = (acc_d < duty);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  // R5
  acc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_i != '0) |-> (acc_q < n_w));
  // R5
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/fd_commit.sv
`timescale 1ns/1ps
// Pending/active configuration pair; pending is applied at a period boundary.
module fd_commit #(
  parameter int HID_W = 5,
  parameter int MND_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             boundary_i,
  input  logic [HID_W-1:0] hid_i,
  input  logic [1:0]       mode_i,
  input  logic [MND_W-1:0] m_i,
  input  logic [MND_W-1:0] n_inv_i,
  input  logic [MND_W-1:0] d_inv_i,
  output logic [HID_W-1:0] act_hid_o,
  output logic [1:0]       act_mode_o,
  output logic [MND_W-1:0] act_m_o,
  output logic [MND_W-1:0] act_n_inv_o,
  output logic [MND_W-1:0] act_d_inv_o,
  output logic             apply_o,
  output logic             done_o
);
  logic [HID_W-1:0] pnd_hid_q;
  logic [1:0]       pnd_mode_q;
  logic [MND_W-1:0] pnd_m_q, pnd_n_inv_q, pnd_d_inv_q;
  logic             pnd_v_q, pnd_v_d;

  always_comb begin
    apply_o = pnd_v_q && boundary_i;
    if (req_i)        pnd_v_d = 1'b1;
    else if (apply_o) pnd_v_d = 1'b0;
    else              pnd_v_d = pnd_v_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pnd_v_q <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      pnd_v_q <= pnd_v_d;
      done_o  <= apply_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pnd_hid_q   <= '0;
      pnd_mode_q  <= frac_div_pkg::FD_BYPASS;
      pnd_m_q     <= MND_W'(1);
      pnd_n_inv_q <= '1;
      pnd_d_inv_q <= '1;
    end else if (req_i) begin
      pnd_hid_q   <= hid_i;
      pnd_mode_q  <= mode_i;
      pnd_m_q     <= m_i;
      pnd_n_inv_q <= n_inv_i;
      pnd_d_inv_q <= d_inv_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_hid_o   <= '0;
      act_mode_o  <= frac_div_pkg::FD_BYPASS;
      act_m_o     <= MND_W'(1);
      act_n_inv_o <= '1;
      act_d_inv_o <= '1;
    end else if (apply_o) begin
      act_hid_o   <= pnd_hid_q;
      act_mode_o  <= pnd_mode_q;
      act_m_o     <= pnd_m_q;
      act_n_inv_o <= pnd_n_inv_q;
      act_d_inv_o <= pnd_d_inv_q;
    end
  end

  // R7
  done_from_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(pnd_v_q));
  // R7
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> ($stable(act_hid_o) && $stable(act_mode_o) && $stable(act_m_o)));
endmodule

// File: rtl/frac_clk_div.sv
`timescale 1ns/1ps
module frac_clk_div #(
  parameter int HID_W = 5,
  parameter int MND_W = 8
) (
  input  logic             clk_src_i,
  input  logic             rst_ni,
  input  logic             cfg_req_i,
  input  logic [HID_W-1:0] cfg_hid_i,
  input  logic [1:0]       cfg_mode_i,
  input  logic [MND_W-1:0] cfg_m_i,
  input  logic [MND_W-1:0] cfg_n_inv_i,
  input  logic [MND_W-1:0] cfg_d_inv_i,
  output logic             clk_en_o,
  output logic             clk_o,
  output logic             commit_done_o
);
  import frac_div_pkg::*;

  logic [HID_W-1:0] act_hid;
  logic [1:0]       act_mode;
  logic [MND_W-1:0] act_m, act_n_inv, act_d_inv;
  logic             apply, tick, dual, step, wrap, lvl, boundary;
  logic             en_d, clk_d;

  fd_commit #(.HID_W(HID_W), .MND_W(MND_W)) u_commit (
    .clk_i       (clk_src_i),
    .rst_ni      (rst_ni),
    .req_i       (cfg_req_i),
    .boundary_i  (boundary),
    .hid_i       (cfg_hid_i),
    .mode_i      (cfg_mode_i),
    .m_i         (cfg_m_i),
    .n_inv_i     (cfg_n_inv_i),
    .d_inv_i     (cfg_d_inv_i),
    .act_hid_o   (act_hid),
    .act_mode_o  (act_mode),
    .act_m_o     (act_m),
    .act_n_inv_o (act_n_inv),
    .act_d_inv_o (act_d_inv),
    .apply_o     (apply),
    .done_o      (commit_done_o)
  );

  fd_prediv #(.HID_W(HID_W)) u_prediv (
    .clk_i  (clk_src_i),
    .rst_ni (rst_ni),
    .clr_i  (apply),
    .hid_i  (act_hid),
    .tick_o (tick)
  );

  fd_mnd #(.MND_W(MND_W)) u_mnd (
    .clk_i   (clk_src_i),
    .rst_ni  (rst_ni),
    .clr_i   (apply),
    .step_i  (step),
    .m_i     (act_m),
    .n_inv_i (act_n_inv),
    .d_inv_i (act_d_inv),
    .wrap_o  (wrap),
    .lvl_o   (lvl)
  );

  always_comb begin
    dual     = (act_mode == FD_DUAL);
    step     = tick && dual;
    boundary = dual ? wrap : tick;
    en_d     = boundary;
    clk_d    = dual ? lvl : tick;
  end

  always_ff @(posedge clk_src_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_en_o <= 1'b0;
      clk_o    <= 1'b0;
    end else begin
      clk_en_o <= en_d;
      clk_o    <= clk_d;
    end
  end

  // R7
  commit_on_edge_chk: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
    commit_done_o |-> clk_en_o);
  // R6
  bypass_clk_chk: assert property (@(posedge clk_src_i) disable iff (!rst_ni)
    ($past(act_mode) != FD_DUAL) |-> (clk_o == clk_en_o));
endmodule

// File: tb/frac_clk_div_tb.sv
`timescale 1ns/1ps
module frac_clk_div_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HID_W = 5;
  localparam int MND_W = 8;
  localparam int MASK  = (1 << MND_W) - 1;
  localparam int WIN   = 3000;

  logic             clk, rst_n, cfg_req;
  logic [HID_W-1:0] cfg_hid;
  logic [1:0]       cfg_mode;
  logic [MND_W-1:0] cfg_m, cfg_n_inv, cfg_d_inv;
  logic             clk_en, clk_out, commit_done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  frac_clk_div #(.HID_W(HID_W), .MND_W(MND_W)) dut_i (
    .clk_src_i     (clk),
    .rst_ni        (rst_n),
    .cfg_req_i     (cfg_req),
    .cfg_hid_i     (cfg_hid),
    .cfg_mode_i    (cfg_mode),
    .cfg_m_i       (cfg_m),
    .cfg_n_inv_i   (cfg_n_inv),
    .cfg_d_inv_i   (cfg_d_inv),
    .clk_en_o      (clk_en),
    .clk_o         (clk_out),
    .commit_done_o (commit_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural cycle model
  int a_hid, a_mode, a_m, a_ninv, a_dinv;
  int p_hid, p_mode, p_m, p_ninv, p_dinv;
  int p_v, pacc, macc;
  int e_en = 0, e_clk = 0, e_done = 0;

  initial begin
    a_hid = 0; a_mode = 0; a_m = 1; a_ninv = MASK; a_dinv = MASK;
    p_hid = 0; p_mode = 0; p_m = 1; p_ninv = MASK; p_dinv = MASK;
    p_v = 0; pacc = 0; macc = 0;
  end

  always @(posedge clk) begin
    int tk, pn, mn, nv, duty, s, wr, bnd, apl, dual;
    if (!rst_n) begin
      a_hid = 0; a_mode = 0; a_m = 1; a_ninv = MASK; a_dinv = MASK;
      p_v = 0; pacc = 0; macc = 0; e_en = 0; e_clk = 0; e_done = 0;
    end else begin
      if (a_hid == 0) begin tk = 1; pn = 0; end
      else if (pacc + 2 >= a_hid + 1) begin tk = 1; pn = pacc + 2 - (a_hid + 1); end
      else begin tk = 0; pn = pacc + 2; end
      dual = (a_mode == 2) ? 1 : 0;
      nv   = ((~a_ninv) & MASK) + a_m;
      duty = (~a_dinv) & MASK;
      wr = 0; mn = macc;
      if (dual == 1 && tk == 1) begin
        s = macc + a_m;
        if (s >= nv) begin wr = 1; mn = s - nv; end
        else mn = s;
      end
      bnd = (dual == 1) ? wr : tk;
      apl = (p_v == 1 && bnd == 1) ? 1 : 0;
      if (apl == 1) begin mn = 0; pn = 0; end
      e_en   = bnd;
      e_clk  = (dual == 1) ? ((mn < duty) ? 1 : 0) : tk;
      e_done = apl;
      if (apl == 1) begin
        a_hid = p_hid; a_mode = p_mode; a_m = p_m; a_ninv = p_ninv; a_dinv = p_dinv;
        p_v = 0;
      end
      if (cfg_req) begin
        p_hid = int'(cfg_hid); p_mode = int'(cfg_mode); p_m = int'(cfg_m);
        p_ninv = int'(cfg_n_inv); p_dinv = int'(cfg_d_inv); p_v = 1;
      end
      pacc = pn; macc = mn;
    end
  end

  // Per-cycle comparison (R1 in reset, R10 timing of each output)
  always @(negedge clk) begin
    if (!finished) begin
      n_run++;
      if (int'(clk_en) != e_en) begin
        n_fail++;
        $display("FAIL %s clk_en_o actual=%0d expected=%0d t=%0t", rst_n ? "R5 R10" : "R1", clk_en, e_en, $time);
      end
      n_run++;
      if (int'(clk_out) != e_clk) begin
        n_fail++;
        $display("FAIL %s clk_o actual=%0d expected=%0d t=%0t", rst_n ? "R6 R10" : "R1", clk_out, e_clk, $time);
      end
      n_run++;
      if (int'(commit_done) != e_done) begin
        n_fail++;
        $display("FAIL %s commit_done_o actual=%0d expected=%0d t=%0t", rst_n ? "R7" : "R1", commit_done, e_done, $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp_lo, input int exp_hi);
    n_run++;
    if (act < exp_lo || act > exp_hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, exp_lo, exp_hi);
    end
  endtask

  task automatic drive_cfg(input int hid, input int mode, input int m, input int n, input int duty);
    @(negedge clk);
    cfg_hid   = HID_W'(hid);
    cfg_mode  = 2'(mode);
    cfg_m     = MND_W'(m);
    cfg_n_inv = MND_W'(~(n - m) & MASK);
    cfg_d_inv = MND_W'(~duty & MASK);
    cfg_req   = 1'b1;
    @(negedge clk);
    cfg_req   = 1'b0;
  endtask

  task automatic wait_commit(input string tag);
    int seen = 0;
    for (int i = 0; i < 6000 && seen == 0; i++) begin
      if (commit_done) seen = 1;
      else @(negedge clk);
    end
    check(tag, seen, 1, 1);
    @(negedge clk);
  endtask

  task automatic measure(input string tag, input int hid, input int mode, input int m, input int n);
    int cnt = 0;
    longint num, den, ex;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (clk_en) cnt++;
    end
    num = longint'(WIN) * ((hid == 0) ? 1 : 2) * ((mode == 2) ? m : 1);
    den = longint'((hid == 0) ? 1 : hid + 1) * ((mode == 2) ? n : 1);
    ex  = num / den;
    check(tag, cnt, int'(ex) - 2, int'(ex) + 2);
  endtask

  task automatic run_cfg(input string tag, input int hid, input int mode, input int m, input int n, input int duty);
    drive_cfg(hid, mode, m, n, duty);
    wait_commit({tag, " R7 commit"});
    measure({tag, " R9 rate"}, hid, mode, m, n);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_req = 1'b0; cfg_hid = '0; cfg_mode = '0;
    cfg_m = '0; cfg_n_inv = '0; cfg_d_inv = '0;
    repeat (4) @(negedge clk);
    // R1: outputs low during reset
    check("R1 clk_en_o in reset", int'(clk_en), 0, 0);
    check("R1 commit_done_o in reset", int'(commit_done), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default pass-through after reset
    measure("R1 default rate", 0, 0, 1, 1);

    run_cfg("R2 hid=3", 3, 0, 1, 1, 0);
    run_cfg("R2 hid=2", 2, 0, 1, 1, 0);
    run_cfg("R2 hid=1", 1, 0, 1, 1, 0);
    run_cfg("R4 R5 3/8", 0, 2, 3, 8, 4);
    run_cfg("R5 R6 2/9 hid=1", 1, 2, 2, 9, 4);
    run_cfg("R5 4/9 hid=4", 4, 2, 4, 9, 5);
    run_cfg("R4 11/50", 0, 2, 11, 50, 25);
    run_cfg("R4 107/269", 0, 2, 107, 269, 134);
    run_cfg("R5 1/1", 0, 2, 1, 1, 1);
    // R3: reserved mode values bypass the M/N stage
    run_cfg("R3 mode1", 2, 1, 3, 8, 4);
    run_cfg("R3 mode3", 0, 3, 3, 8, 4);
    // R8: slow period, then two back-to-back requests; the later one wins
    run_cfg("R8 slow", 5, 2, 1, 40, 20);
    drive_cfg(0, 2, 2, 9, 4);
    drive_cfg(3, 2, 3, 8, 4);
    wait_commit("R8 commit");
    measure("R8 latest applied", 3, 2, 3, 8);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule